// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block is the host side of a one-bit serial configuration link to a downstream programmable device. On a start pulse it runs the complete load sequence. It first pulses the target's active-low configuration reset and waits for the target's active-low status line to answer in both directions. It then lets the target settle, shifts the supplied bytes out one bit at a time on a host-driven configuration clock, and watches the target for an early finish or a load error. After the final byte it keeps clocking filler bytes until the target reports that start-up is complete.

Bytes arrive on a valid/ready stream, and a last flag marks the final byte of the image. An internal prescaler turns the system clock into a microsecond time base, and every wait and timeout is counted in microseconds. When a run ends, the block leaves either a success flag or a failure flag set, together with a code that names the step that failed. It also counts the bytes it has accepted, which gives the offset when a load error occurs.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset: `busy`, `cfg_ok`, `cfg_fail` and `in_ready` are 0, `cfg_err` is 0, and `tgt_rst_n` and `tgt_clk` are 1.
- R2: A `start` pulse while idle drives `tgt_rst_n` low for at least `HOLD_US` microseconds. The block then waits for `tgt_stat_n` to go low. If it stays high for `STAT_TMO_US` microseconds, the run fails with code 1.
- R3: Once `tgt_stat_n` is low, `tgt_rst_n` is released and the block waits for `tgt_stat_n` to return high. If it stays low for `STAT_TMO_US` microseconds, the run fails with code 2.
- R4: The first falling edge of `tgt_clk` comes at least `SETTLE_US` microseconds after `tgt_stat_n` has returned high.
- R5: Each byte is sent most-significant bit first. `tgt_data` changes only while `tgt_clk` falls or is low, and the target samples it on the rising edge. Each low half and each high half of `tgt_clk` lasts `HALF_CLKS` system clocks.
- R6: `in_ready` is high only in the gap between bytes, with `tgt_clk` parked high. A byte is taken on a clock where `in_valid` and `in_ready` are both high, and its shift starts on the next clock.
- R7: If `tgt_done` is high at a byte boundary, no further bytes are accepted and the block goes straight to the start-up phase without error.
- R8: If `tgt_stat_n` is low at a byte boundary during loading, the run fails with code 3. `cfg_err_ofs` then holds the number of bytes accepted so far.
- R9: After the byte flagged `in_last` (or after an early finish), the block clocks 0xFF bytes. Before each filler byte it checks the target. The run succeeds on the `DONE_HITS`-th check that finds `tgt_done` high and `tgt_stat_n` high. If the run has not succeeded within `DONE_TMO_US` microseconds of entering this phase, it fails with code 4.
- R10: A failure releases `tgt_rst_n` and parks `tgt_clk` high, clears `busy`, sets `cfg_fail` and leaves `cfg_err` in the range 1 to 4. `cfg_ok` and `cfg_fail` are never high together, and success leaves `cfg_err` at 0.
- R11: A `start` pulse while `busy` is ignored. In particular, `tgt_rst_n` is not pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run (single-cycle pulse) |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | Current byte is the last byte of the image |
| in_ready | output | 1 | Loader takes a byte on this clock if `in_valid` is high |
| tgt_rst_n | output | 1 | Active-low configuration reset to the target |
| tgt_clk | output | 1 | Configuration clock to the target |
| tgt_data | output | 1 | Serial configuration data to the target |
| tgt_stat_n | input | 1 | Target status line, active low (reset acknowledge / load error) |
| tgt_done | input | 1 | Target start-up complete |
| busy | output | 1 | A run is in progress |
| cfg_ok | output | 1 | Last run succeeded |
| cfg_fail | output | 1 | Last run failed |
| cfg_err | output | 3 | Failure code: 1 reset ack timeout, 2 release timeout, 3 load error, 4 start-up timeout |
| cfg_err_ofs | output | OFS_W | Bytes accepted in the current or last run |

## Verification
Almost every internal state of this sequencer shows up at the target pins or in the handshake within one half period of the configuration clock. Corruption in the shifter appears at once as wrong bits captured on rising clock edges, and a miscounted bit counter shifts every later byte or changes how many bytes the target receives. A wrong timer or wrong state decoding appears as a reset pulse, settle gap or timeout whose length falls outside its bound, or as the wrong failure code when the run ends. A miscounted filler loop appears as the wrong number of 0xFF bytes reaching the target before success is reported.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int CLKS_PER_US = 100,
  parameter int HOLD_US     = 10,
  parameter int STAT_TMO_US = 500000,
  parameter int SETTLE_US   = 10000,
  parameter int DONE_TMO_US = 200000,
  parameter int HALF_CLKS   = 1,
  parameter int DONE_HITS   = 9,
  parameter int OFS_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic             tgt_rst_n,
  output logic             tgt_clk,
  output logic             tgt_data,
  input  logic             tgt_stat_n,
  input  logic             tgt_done,
  output logic             busy,
  output logic             cfg_ok,
  output logic             cfg_fail,
  output logic [2:0]       cfg_err,
  output logic [OFS_W-1:0] cfg_err_ofs
);

  localparam int T1   = (HOLD_US > STAT_TMO_US) ? HOLD_US : STAT_TMO_US;
  localparam int T2   = (SETTLE_US > DONE_TMO_US) ? SETTLE_US : DONE_TMO_US;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int TW   = $clog2(TMAX + 1) + 1;
  localparam int PW   = $clog2(CLKS_PER_US) + 1;
  localparam int HW   = $clog2(HALF_CLKS) + 1;
  localparam int DW   = $clog2(DONE_HITS) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_WLO, S_WHI, S_SETTLE, S_FETCH, S_SHIFT, S_PAD
  } state_t;

  state_t           st;
  logic [PW-1:0]    pre;
  logic [TW-1:0]    us;
  logic [HW-1:0]    hc;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             ph, last_q, pad_q, rst_q;
  logic [DW-1:0]    hits;
  logic [OFS_W-1:0] ofs;

  assign busy        = (st != S_IDLE);
  assign in_ready    = (st == S_FETCH) && !tgt_done && tgt_stat_n;
  assign tgt_rst_n   = rst_q;
  assign tgt_clk     = ph;
  assign tgt_data    = sh[7];
  assign cfg_err_ofs = ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pre <= '0; us <= '0; hc <= '0; bitn <= '0;
      sh <= 8'hFF; ph <= 1'b1; last_q <= 1'b0; pad_q <= 1'b0;
      rst_q <= 1'b1; hits <= '0; ofs <= '0;
      cfg_ok <= 1'b0; cfg_fail <= 1'b0; cfg_err <= 3'd0;
    end else begin
      if (pre == PW'(CLKS_PER_US - 1)) begin
        pre <= '0;
        us  <= us + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          cfg_ok <= 1'b0; cfg_fail <= 1'b0; cfg_err <= 3'd0;
          ofs <= '0; hits <= '0; pad_q <= 1'b0; rst_q <= 1'b0;
          pre <= '0; us <= '0; st <= S_HOLD;
        end
        S_HOLD: if (us >= TW'(HOLD_US)) begin
          pre <= '0; us <= '0; st <= S_WLO;
        end
        S_WLO: if (!tgt_stat_n) begin
          rst_q <= 1'b1; pre <= '0; us <= '0; st <= S_WHI;
        end else if (us >= TW'(STAT_TMO_US)) begin
          st <= S_IDLE; rst_q <= 1'b1; ph <= 1'b1;
          cfg_fail <= 1'b1; cfg_err <= 3'd1;
        end
        S_WHI: if (tgt_stat_n) begin
          pre <= '0; us <= '0; st <= S_SETTLE;
        end else if (us >= TW'(STAT_TMO_US)) begin
          st <= S_IDLE; rst_q <= 1'b1; ph <= 1'b1;
          cfg_fail <= 1'b1; cfg_err <= 3'd2;
        end
        S_SETTLE: if (us >= TW'(SETTLE_US)) st <= S_FETCH;
        S_FETCH: if (tgt_done) begin
          pad_q <= 1'b1; pre <= '0; us <= '0; st <= S_PAD;
        end else if (!tgt_stat_n) begin
          st <= S_IDLE; rst_q <= 1'b1; ph <= 1'b1;
          cfg_fail <= 1'b1; cfg_err <= 3'd3;
        end else if (in_valid) begin
          sh <= in_data; last_q <= in_last; ofs <= ofs + 1'b1;
          bitn <= '0; hc <= '0; ph <= 1'b0; st <= S_SHIFT;
        end
        S_SHIFT: if (hc == HW'(HALF_CLKS - 1)) begin
          hc <= '0;
          if (!ph) begin
            ph <= 1'b1;
          end else if (bitn == 3'd7) begin
            if (pad_q) begin
              st <= S_PAD;
            end else if (last_q) begin
              pad_q <= 1'b1; pre <= '0; us <= '0; st <= S_PAD;
            end else begin
              st <= S_FETCH;
            end
          end else begin
            bitn <= bitn + 1'b1;
            sh <= {sh[6:0], 1'b1};
            ph <= 1'b0;
          end
        end else begin
          hc <= hc + 1'b1;
        end
        S_PAD: if (tgt_done && tgt_stat_n && hits == DW'(DONE_HITS - 1)) begin
          st <= S_IDLE; cfg_ok <= 1'b1;
        end else if (us >= TW'(DONE_TMO_US)) begin
          st <= S_IDLE; rst_q <= 1'b1; ph <= 1'b1;
          cfg_fail <= 1'b1; cfg_err <= 3'd4;
        end else begin
          if (tgt_done && tgt_stat_n) hits <= hits + 1'b1;
          sh <= 8'hFF; bitn <= '0; hc <= '0; ph <= 1'b0; st <= S_SHIFT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ready_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tgt_clk);
  assert_accept_shifts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !tgt_clk);
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_clk) |-> $stable(tgt_data));
  assert_reset_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> busy);
  assert_abort_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_fail) |-> (tgt_rst_n && tgt_clk && !busy));
  assert_result_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_fail));
  assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fail |-> (cfg_err != 3'd0 && cfg_err <= 3'd4));
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tgt_rst_n && start) |=> tgt_rst_n);

endmodule

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
  localparam int CPU = 2, HOLD = 3, STMO = 40, SETL = 5, DTMO = 400, HALF = 2, HITS = 9;
  localparam int NC = 8;
  // modes: 0 normal, 1 early finish, 2 load error, 3 no ack, 4 stuck ack, 5 never done
  localparam int T_MODE [NC] = '{0, 0, 1, 2, 3, 4, 5, 2};
  localparam int T_N    [NC] = '{4, 1, 6, 5, 3, 3, 2, 2};
  localparam int T_ARG  [NC] = '{0, 0, 3, 2, 0, 0, 0, 1};
  localparam int T_CODE [NC] = '{0, 0, 0, 3, 1, 2, 4, 3};
  localparam int T_ACC  [NC] = '{4, 1, 3, 2, 0, 0, 2, 1};

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, tgt_rst_n, tgt_clk, tgt_data, busy, cfg_ok, cfg_fail;
  logic [2:0] cfg_err;
  logic [15:0] cfg_err_ofs;
  logic m_stat_n = 1, m_done = 0;

  serial_cfg_loader #(.CLKS_PER_US(CPU), .HOLD_US(HOLD), .STAT_TMO_US(STMO),
    .SETTLE_US(SETL), .DONE_TMO_US(DTMO), .HALF_CLKS(HALF), .DONE_HITS(HITS),
    .OFS_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .tgt_rst_n(tgt_rst_n), .tgt_clk(tgt_clk),
    .tgt_data(tgt_data), .tgt_stat_n(m_stat_n), .tgt_done(m_done), .busy(busy),
    .cfg_ok(cfg_ok), .cfg_fail(cfg_fail), .cfg_err(cfg_err), .cfg_err_ofs(cfg_err_ofs));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  bit no_lo = 0, stuck_lo = 0, err_hit = 0, saw_low = 0, prev_clk = 1;
  int err_at = -1, done_bits = 1 << 30, lo_dly = 0, hi_dly = 0, bits = 0, cap_n = 0;
  int rst_len = 0, t_hi = 0, t_low = 0, low_run = 0, half_bad = 0, rdy_bad = 0;
  logic [7:0] cur = 0;
  logic [7:0] cap [64];

  always @(negedge clk) begin
    if (in_ready && !tgt_clk) rdy_bad++;
    if (!tgt_rst_n) begin
      rst_len++; bits = 0; cap_n = 0; m_done = 0; err_hit = 0; hi_dly = 0; saw_low = 0;
      if (!no_lo) begin lo_dly++; if (lo_dly >= 2) m_stat_n = 0; end
    end else begin
      lo_dly = 0;
      if (!m_stat_n && !stuck_lo && !err_hit) begin
        hi_dly++;
        if (hi_dly >= 4) begin m_stat_n = 1; t_hi = cyc; end
      end
      if (!tgt_clk && !saw_low) begin saw_low = 1; t_low = cyc; end
      if (tgt_clk && !prev_clk) begin
        cur = {cur[6:0], tgt_data};
        bits++;
        if (bits % 8 == 0) begin
          if (cap_n < 64) cap[cap_n] = cur;
          cap_n++;
          if (cap_n == err_at) begin m_stat_n = 0; err_hit = 1; end
        end
        if (bits >= done_bits) m_done = 1;
      end
    end
    if (!tgt_clk) low_run++;
    else begin
      if (low_run != 0 && low_run != HALF) half_bad++;
      low_run = 0;
    end
    prev_clk = tgt_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int c, input int i);
    return 8'((c * 37 + i * 91 + 5) ^ 8'hA5);
  endfunction

  function automatic string tag(input int m);
    case (m)
      0: return "R9"; 1: return "R7"; 2: return "R8";
      3: return "R2"; 4: return "R3"; default: return "R9";
    endcase
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t0, t_acc, t_end, acc, m, n;
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !cfg_ok && !cfg_fail && !in_ready, "R1 flags", {busy, cfg_ok, cfg_fail, in_ready}, 0);
    chk(tgt_rst_n && tgt_clk && cfg_err == 0, "R1 pins", {tgt_rst_n, tgt_clk}, 3);
    rst_n = 1;
    @(posedge clk); #1;
    chk(!busy && tgt_rst_n && tgt_clk, "R1 after release", busy, 0);

    for (int c = 0; c < NC; c++) begin
      m = T_MODE[c]; n = T_N[c];
      no_lo = (m == 3); stuck_lo = (m == 4);
      err_at = (m == 2) ? T_ARG[c] : -1;
      done_bits = (m == 0) ? 8 * (n + 2) : (m == 1) ? 8 * T_ARG[c] : (1 << 30);
      m_stat_n = 1; m_done = 0; rst_len = 0;
      start = 1; @(posedge clk); #1; start = 0;
      t0 = cyc; t_acc = cyc; acc = 0;
      for (int i = 0; i < n; i++) begin
        in_data = pat(c, i); in_last = (i == n - 1); in_valid = 1;
        while (busy && !in_ready && cyc - t0 < 20000) begin @(posedge clk); #1; end
        if (!busy) break;
        @(posedge clk); #1;
        acc++; t_acc = cyc;
        if (c == 0 && i == 0) begin
          start = 1; @(posedge clk); #1; start = 0;
          chk(tgt_rst_n && busy, "R11 start while busy", tgt_rst_n, 1);
        end
      end
      in_valid = 0; in_last = 0;
      while (busy && cyc - t0 < 20000) begin @(posedge clk); #1; end
      t_end = cyc;
      chk(cfg_err == T_CODE[c], tag(m), cfg_err, T_CODE[c]);
      chk(cfg_ok == (T_CODE[c] == 0) && cfg_fail == (T_CODE[c] != 0), "R10 flags",
          {cfg_ok, cfg_fail}, (T_CODE[c] == 0) ? 2 : 1);
      chk(acc == T_ACC[c], "R6 R7 bytes accepted", acc, T_ACC[c]);
      for (int i = 0; i < acc; i++)
        chk(cap[i] == pat(c, i), "R5 captured byte", cap[i], pat(c, i));
      if (T_CODE[c] != 0)
        chk(tgt_rst_n && tgt_clk && !busy, "R10 park after abort", {tgt_rst_n, tgt_clk, busy}, 6);
      if (m <= 1) begin
        chk(cap_n == acc + ((m == 0) ? 10 : 8), "R9 filler count", cap_n, acc + ((m == 0) ? 10 : 8));
        chk(cap[acc] == 8'hFF, "R9 filler value", cap[acc], 255);
      end
      if (m == 0) begin
        chk(rst_len >= HOLD * CPU, "R2 reset hold", rst_len, HOLD * CPU);
        chk(t_low - t_hi >= SETL * CPU, "R4 settle gap", t_low - t_hi, SETL * CPU);
      end
      if (m == 2) chk(cfg_err_ofs == 16'(T_ARG[c]), "R8 offset", cfg_err_ofs, T_ARG[c]);
      if (m == 3) chk(t_end - t0 >= (HOLD + STMO) * CPU, "R2 timeout length", t_end - t0, (HOLD + STMO) * CPU);
      if (m == 4) chk(t_end - t0 >= STMO * CPU, "R3 timeout length", t_end - t0, STMO * CPU);
      if (m == 5) chk(t_end - t_acc >= DTMO * CPU, "R9 timeout length", t_end - t_acc, DTMO * CPU);
      repeat (3) @(posedge clk);
      #1;
    end
    chk(half_bad == 0, "R5 half period", half_bad, 0);
    chk(rdy_bad == 0, "R6 ready only parked", rdy_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule